// File: doc/BRIEF.md
# Dual-Mode Glitch-Free Clock Selector

This block picks one of two input clocks and drives one output clock together with its complement. The mode input chooses between two ways of switching. In direct mode the select steers a plain combinational path, so the output follows the chosen input at once. Direct mode never depends on the other clock, which makes it the safe choice at power-up when one input, or both, may not be toggling yet. In glitch-free mode a change of select becomes a handshake between the two clock domains. The old clock is gated off during its low phase, and only after that is the new clock gated on during its own low phase. No runt pulse and no shortened phase can then reach the output.

Each input has its own lane. A lane holds a falling-edge synchronizer chain that produces its glitch-free enable, and a second chain that brings the active-low output enable into that clock's domain. Because the output enable is applied only on falling edges, turning the output on or off never cuts a pulse short. The two status outputs show which lane currently holds the glitch-free enable. The inputs have no pull resistors inside, so the integration ties the select high (input A) and the mode low (direct) wherever they are left unused. The inputs may run anywhere from 1 MHz to 167 MHz and need not be related in frequency.

Top module: `gfmux_top`

## Requirements
- R1: While `rst_n` is low, `clk_out`, `clk_out_n`, `act_a` and `act_b` are all 0.
- R2: With `mode_gf` = 0 and the output enabled, `clk_out` equals `clk_a` when `sel_a` = 1 and `clk_b` when `sel_a` = 0, and `clk_out_n` is its inverse.
- R3: In direct mode the output follows the selected input even while the deselected input clock is stopped.
- R4: In glitch-free mode, with the select held steady, `act_a` and `act_b` are never both 1.
- R5: In glitch-free mode, after `sel_a` changes and is then held, the new input's status bit is 1 and the old one's is 0 within 3 falling edges of the old clock followed by 3 falling edges of the new clock. From then on `clk_out` follows the new input.
- R6: In glitch-free mode, no high or low phase of `clk_out` is shorter than the shorter half-period of the two inputs. This includes phases around a switch and around changes of `oe_n`.
- R7: With `oe_n` = 1 held for `SYNC_STAGES`+1 falling edges of the selected clock, `clk_out` and `clk_out_n` are both held at 0.
- R8: `clk_out` and `clk_out_n` are never both 1. While the output is enabled and driven by a lane, `clk_out_n` is the inverse of `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Input clock A |
| clk_b | input | 1 | Input clock B |
| rst_n | input | 1 | Asynchronous active-low reset of all synchronizer flops |
| sel_a | input | 1 | Select: 1 picks input A, 0 picks input B |
| mode_gf | input | 1 | Switching mode: 0 direct, 1 glitch-free |
| oe_n | input | 1 | Active-low output enable; 1 parks both outputs low |
| clk_out | output | 1 | Selected clock, true polarity |
| clk_out_n | output | 1 | Selected clock, complement polarity |
| act_a | output | 1 | Glitch-free enable of lane A is set |
| act_b | output | 1 | Glitch-free enable of lane B is set |

## Verification
The bench drives two unrelated clocks, with a 10 ns and a 13 ns period. In direct mode it selects each input in turn, once with both clocks running and once with the unused clock stopped. This separates a true combinational pass-through from a selector that stalls waiting on the idle clock. In glitch-free mode it switches A to B and back, and toggles the output enable while the output is switching. A timer measures every output phase, so any runt or shortened phase shows up, and a watch on the two status bits catches them both being set at the same time. The output-enable runs, done in both modes, check that the true and complement outputs are parked low and that toggling resumes afterwards.

// File: rtl/gfmux_pkg.sv
package gfmux_pkg;

  // switching behaviour picked by the mode pin
  typedef enum logic {
    MODE_DIRECT     = 1'b0,
    MODE_GLITCHFREE = 1'b1
  } mux_mode_e;

  // lane numbering inside the selector
  localparam int unsigned LANE_A = 0;
  localparam int unsigned LANE_B = 1;
  localparam int unsigned LANES  = 2;

endpackage

// File: rtl/gfmux_sync_neg.sv
// Multi-stage synchronizer clocked on the falling edge of its own clock.
module gfmux_sync_neg #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];

endmodule

// File: rtl/gfmux_lane.sv
// One input lane: glitch-free enable chain, output-enable chain, gating.
module gfmux_lane #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic want_i,      // this lane is the selected one
  input  logic other_en_i,  // enable state of the opposite lane
  input  logic oe_n_i,      // raw active-low output enable
  output logic en_o,        // glitch-free enable of this lane
  output logic oe_o,        // output enable, in this clock's domain
  output logic gated_o,     // clock gated by both enables (glitch-free path)
  output logic pass_o,      // clock gated by output enable only (direct path)
  output logic drive_o      // lane is driving the glitch-free path
);

  logic req_d;

  // a lane may only request once the opposite lane has let go
  assign req_d = want_i & ~other_en_i;

  gfmux_sync_neg #(.STAGES(STAGES)) u_en_sync (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .d_i   (req_d),
    .q_o   (en_o)
  );

  gfmux_sync_neg #(.STAGES(STAGES)) u_oe_sync (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .d_i   (~oe_n_i),
    .q_o   (oe_o)
  );

  // enables only change on falling edges, so these ANDs never cut a high phase
  assign drive_o = en_o & oe_o;
  assign gated_o = clk_i & drive_o;
  assign pass_o  = clk_i & oe_o;

endmodule

// File: rtl/gfmux_top.sv
module gfmux_top
  import gfmux_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel_a,
  input  logic mode_gf,
  input  logic oe_n,
  output logic clk_out,
  output logic clk_out_n,
  output logic act_a,
  output logic act_b
);

  localparam int unsigned STG = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [LANES-1:0] lane_clk;
  logic [LANES-1:0] lane_want;
  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] lane_oe;
  logic [LANES-1:0] lane_gated;
  logic [LANES-1:0] lane_pass;
  logic [LANES-1:0] lane_drive;

  mux_mode_e mode;
  logic      raw_out;
  logic      out_on;

  assign mode = mux_mode_e'(mode_gf);

  assign lane_clk[LANE_A]  = clk_a;
  assign lane_clk[LANE_B]  = clk_b;
  assign lane_want[LANE_A] = sel_a;
  assign lane_want[LANE_B] = ~sel_a;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      gfmux_lane #(.STAGES(STG)) u_lane (
        .clk_i      (lane_clk[i]),
        .rst_n      (rst_n),
        .want_i     (lane_want[i]),
        .other_en_i (lane_en[LANES-1-i]),
        .oe_n_i     (oe_n),
        .en_o       (lane_en[i]),
        .oe_o       (lane_oe[i]),
        .gated_o    (lane_gated[i]),
        .pass_o     (lane_pass[i]),
        .drive_o    (lane_drive[i])
      );
    end
  endgenerate

  always_comb begin
    if (mode == MODE_GLITCHFREE) begin
      raw_out = |lane_gated;
      out_on  = |lane_drive;
    end else begin
      raw_out = sel_a ? lane_pass[LANE_A] : lane_pass[LANE_B];
      out_on  = sel_a ? lane_oe[LANE_A]   : lane_oe[LANE_B];
    end
  end

  assign clk_out   = raw_out;
  assign clk_out_n = out_on & ~raw_out;
  assign act_a     = lane_en[LANE_A];
  assign act_b     = lane_en[LANE_B];

endmodule

// File: rtl/gfmux_chk.sv
module gfmux_chk (
  input logic clk_a,
  input logic clk_b,
  input logic rst_n,
  input logic sel_a,
  input logic mode_gf,
  input logic oe_n,
  input logic clk_out,
  input logic clk_out_n,
  input logic act_a,
  input logic act_b
);

  // R4: both lanes never enabled together, seen from lane A's clock
  p_one_lane_r4 : assert property (@(negedge clk_a) disable iff (!rst_n)
    !(act_a && act_b));

  // R4: same, seen from lane B's clock
  p_one_lane_b_r4 : assert property (@(negedge clk_b) disable iff (!rst_n)
    !(act_a && act_b));

  // R8: true and complement outputs never high together
  p_comp_low_r8 : assert property (@(negedge clk_a) disable iff (!rst_n)
    !(clk_out && clk_out_n));

  // R7: enable held off for three falling edges in direct mode on A parks the output
  p_oe_off_r7 : assert property (@(negedge clk_a) disable iff (!rst_n)
    (oe_n && $past(oe_n) && $past(oe_n, 2) && !mode_gf && !$past(mode_gf)
     && sel_a && $past(sel_a)) |-> (!clk_out && !clk_out_n));

endmodule

bind gfmux_top gfmux_chk u_chk (
  .clk_a     (clk_a),
  .clk_b     (clk_b),
  .rst_n     (rst_n),
  .sel_a     (sel_a),
  .mode_gf   (mode_gf),
  .oe_n      (oe_n),
  .clk_out   (clk_out),
  .clk_out_n (clk_out_n),
  .act_a     (act_a),
  .act_b     (act_b)
);

// File: tb/gfmux_top_tb_top.sv
`timescale 1ns/1ps
module gfmux_top_tb_top;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n = 1'b0;
  logic sel_a = 1'b1;
  logic mode_gf = 1'b0;
  logic oe_n = 1'b0;
  logic clk_out, clk_out_n, act_a, act_b;

  bit run_a = 1'b1;
  bit run_b = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // phase measurement in glitch-free mode
  bit  meas_on   = 1'b0;
  bit  have_last = 1'b0;
  real last_t    = 0.0;
  int  short_cnt = 0;
  localparam real MIN_HALF = 5.0;

  // overlap watch for R4
  bit watch_on  = 1'b0;
  int both_seen = 0;

  // clk_a is the 100 MHz reference, clk_b is unrelated at 13 ns
  always #5    if (run_a) clk_a = ~clk_a;
  always #6.5  if (run_b) clk_b = ~clk_b;

  gfmux_top dut_i (
    .clk_a     (clk_a),
    .clk_b     (clk_b),
    .rst_n     (rst_n),
    .sel_a     (sel_a),
    .mode_gf   (mode_gf),
    .oe_n      (oe_n),
    .clk_out   (clk_out),
    .clk_out_n (clk_out_n),
    .act_a     (act_a),
    .act_b     (act_b)
  );

  always @(clk_out) begin
    if (meas_on) begin
      if (have_last && (($realtime - last_t) < MIN_HALF - 0.001)) short_cnt++;
      last_t    = $realtime;
      have_last = 1'b1;
    end
  end

  always #0.5 if (watch_on && act_a && act_b) both_seen++;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [3:0] got, input logic [3:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) begin
      if (run_a) @(negedge clk_a);
      if (run_b) @(negedge clk_b);
    end
  endtask

  // output must follow the chosen clock, complement inverted
  task automatic follow(input bit use_a, input string tag);
    for (int k = 0; k < 3; k++) begin
      if (use_a) @(posedge clk_a); else @(posedge clk_b);
      #1;
      chk(clk_out === 1'b1 && clk_out_n === 1'b0, tag, "high phase",
          {2'b00, clk_out, clk_out_n}, 4'b0010);
      if (use_a) @(negedge clk_a); else @(negedge clk_b);
      #1;
      chk(clk_out === 1'b0 && clk_out_n === 1'b1, tag, "low phase",
          {2'b00, clk_out, clk_out_n}, 4'b0001);
    end
  endtask

  task automatic parked(input string tag);
    for (int k = 0; k < 6; k++) begin
      #3.1;
      chk(clk_out === 1'b0 && clk_out_n === 1'b0, tag, "parked low",
          {2'b00, clk_out, clk_out_n}, 4'b0000);
    end
  endtask

  task automatic t_reset();
    @(posedge clk_a); #1;
    chk(clk_out === 1'b0 && clk_out_n === 1'b0 && act_a === 1'b0 && act_b === 1'b0,
        "R1", "outputs in reset", {clk_out, clk_out_n, act_a, act_b}, 4'b0000);
    @(posedge clk_b); #1;
    chk(clk_out === 1'b0 && clk_out_n === 1'b0 && act_a === 1'b0 && act_b === 1'b0,
        "R1", "outputs in reset (B high)", {clk_out, clk_out_n, act_a, act_b}, 4'b0000);
    rst_n = 1'b1;
    settle(4);
  endtask

  task automatic t_direct();
    mode_gf = 1'b0; sel_a = 1'b1; settle(4);
    follow(1'b1, "R2");
    sel_a = 1'b0; settle(4);
    follow(1'b0, "R2");
  endtask

  task automatic t_direct_stopped();
    mode_gf = 1'b0; sel_a = 1'b0;
    @(negedge clk_a); run_a = 1'b0;
    settle(4);
    follow(1'b0, "R3");
    run_a = 1'b1; sel_a = 1'b1; settle(4);
    @(negedge clk_b); run_b = 1'b0;
    settle(4);
    follow(1'b1, "R3");
    run_b = 1'b1; settle(4);
  endtask

  task automatic t_oe();
    mode_gf = 1'b0; sel_a = 1'b1; oe_n = 1'b1; settle(4);
    parked("R7");
    oe_n = 1'b0; settle(4);
    follow(1'b1, "R7");
    mode_gf = 1'b1; sel_a = 1'b0; settle(6);
    oe_n = 1'b1; settle(4);
    parked("R7");
    oe_n = 1'b0; settle(4);
    follow(1'b0, "R7");
  endtask

  task automatic t_glitchfree();
    mode_gf = 1'b1; sel_a = 1'b1; settle(6);
    chk(act_a === 1'b1 && act_b === 1'b0, "R5", "status on A",
        {2'b00, act_a, act_b}, 4'b0010);
    short_cnt = 0; have_last = 1'b0; meas_on = 1'b1;
    both_seen = 0; watch_on = 1'b1;
    follow(1'b1, "R8");
    // A to B
    sel_a = 1'b0;
    repeat (3) @(negedge clk_a);
    repeat (3) @(negedge clk_b);
    #1;
    chk(act_a === 1'b0 && act_b === 1'b1, "R5", "status on B after switch",
        {2'b00, act_a, act_b}, 4'b0001);
    follow(1'b0, "R5");
    // B to A
    sel_a = 1'b1;
    repeat (3) @(negedge clk_b);
    repeat (3) @(negedge clk_a);
    #1;
    chk(act_a === 1'b1 && act_b === 1'b0, "R5", "status on A after switch",
        {2'b00, act_a, act_b}, 4'b0010);
    follow(1'b1, "R5");
    // enable toggles while switching
    oe_n = 1'b1; #17; sel_a = 1'b0; #23; oe_n = 1'b0;
    settle(6);
    oe_n = 1'b1; #9; oe_n = 1'b0; settle(6);
    follow(1'b0, "R8");
    meas_on = 1'b0; watch_on = 1'b0;
    chk(short_cnt == 0, "R6", "short output phases", short_cnt[3:0], 4'd0);
    chk(both_seen == 0, "R4", "both lanes active", both_seen[3:0], 4'd0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    #23;
    t_reset();
    t_direct();
    t_direct_stopped();
    t_glitchfree();
    t_oe();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule